// File: doc/BRIEF.md
# Transmit Descriptor Ring Processor

This block walks a list of transmit descriptors kept in a word-addressed memory and turns each owned descriptor into a stream of bytes. A descriptor is four 32-bit words: word 0 carries status and the ownership flag, word 1 carries control flags and two buffer sizes, word 2 holds the first buffer address, and word 3 holds either the second buffer address or a link to the next descriptor. For every descriptor the block reads the four words and checks that it owns the descriptor. It then picks a buffer, sends that buffer's bytes out with frame-start and frame-end markers, and writes the status back to memory.

Software gives the block a list base address, raises the enable bit to start, and pulses the poll strobe to make the block look at the list again after it has stopped. Three one-cycle event outputs report a finished descriptor with interrupt request, a run of descriptors that were not owned, and the transmitter being switched off. The block stops at the first descriptor it does not own, and it does not start a new descriptor while enable is low.

Top module: `tx_desc_walker`

## Requirements
- R1: After a synchronous reset, out_valid, mem_rd, mem_wr and every event output are 0, and next_desc is 0.
- R2: When enable rises while the block is stopped, the descriptor pointer is loaded from list_base with bit 31 and bits 1:0 forced to zero. Processing starts on that rising edge, or on a poll pulse while enable is high.
- R3: A descriptor whose word 0 bit 31 is clear causes no bytes and no memory writes. Processing stops there, and next_desc keeps the address of that descriptor.
- R4: Each time a descriptor is found not owned, an idle counter is compared with IDLE_LIMIT. If the counter is greater than IDLE_LIMIT, evt_no_buf pulses and the counter goes to zero; otherwise the counter increments. A poll pulse sets the counter to IDLE_LIMIT.
- R5: The next descriptor address is chosen by priority: the cleaned list_base if word 1 bit 25 is set, else the cleaned word 3 if word 1 bit 24 is set, else the current address plus 16.
- R6: When word 1 bits 10:0 are nonzero, that value is the byte count and word 2 is the buffer address. Otherwise the byte count is word 1 bits 21:11 and the buffer address is word 3. Buffer addresses have bit 31 and bits 1:0 forced to zero.
- R7: Buffer bytes come out in ascending address order, with the lowest byte lane of each word first. A byte stays valid with stable data and markers until out_ready is high, and the memory port is idle while a byte waits.
- R8: out_first is high only on the first byte of a descriptor whose word 1 bit 29 is set. out_last is high only on the final byte of a descriptor whose word 1 bit 30 is set.
- R9: Write-back of a data descriptor clears word 0 bits 1, 8, 9, 10, 11, 14 and 15. If word 1 bit 30 is set, only word 0 is written, and its bit 31 is cleared. If bit 30 is clear, all four words are written back, with bit 31 kept.
- R10: A descriptor with word 1 bit 27 set sends no bytes. Its four words are written back as 0x7FFFFFFF, 0xFFFFFFFF, 0xFFFFFFFF, 0xFFFFFFFF.
- R11: evt_complete pulses once after write-back when word 1 bit 31 is set and the descriptor is either a setup descriptor or a last segment.
- R12: A falling edge of enable gives a one-cycle evt_halted pulse. While enable is low, no descriptor fetch begins, and poll has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Transmit enable |
| poll | input | 1 | One-cycle request to look at the list again |
| list_base | input | ADDR_W | Byte address of the first descriptor |
| mem_rd | output | 1 | Memory read request; data returns one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Byte value |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Final byte of a frame |
| next_desc | output | ADDR_W | Byte address of the next descriptor to fetch |
| evt_complete | output | 1 | Completion pulse, interrupt requested |
| evt_no_buf | output | 1 | Pulse when not-owned descriptors exceed the idle limit |
| evt_halted | output | 1 | Pulse on enable turning off |

## Verification
The bench builds the block with ADDR_W at 32 and IDLE_LIMIT lowered to 3. With that limit, the exact cycle on which the no-buffer event fires is reached after five restarts, and the bench can also show that a poll preloads the counter. The full 32-bit address width lets the bench pass addresses with bit 31 and the low bits set, so it can check that they are cleaned. The bench also throttles out_ready in a fixed pattern, so that bytes wait across word boundaries and the stall behaviour is exercised.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int WORD_W = 32;
  localparam int SIZE_W = 11;

  // control/status bit positions inside a descriptor
  localparam int OWN_B = 31;  // word 0
  localparam int IC_B  = 31;  // word 1
  localparam int LS_B  = 30;
  localparam int FS_B  = 29;
  localparam int SET_B = 27;
  localparam int ER_B  = 25;
  localparam int CH_B  = 24;

  // error flags and summary flag cleared on write-back
  localparam logic [WORD_W-1:0] ERR_CLR = 32'h0000_CF02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CAPT, ST_PLAN, ST_BREAD, ST_BLOAD, ST_BOUT, ST_WBACK
  } walk_st_t;

  typedef enum logic [1:0] {WB_SETUP, WB_FINAL, WB_PART} wb_kind_t;
endpackage

// File: rtl/tdw_next_ptr.sv
module tdw_next_ptr
  import tdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic [WORD_W-1:0] ctrl,
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] AMASK = {1'b0, {(ADDR_W-3){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(16);

  logic [WORD_W-1:0] ctrl_seen;
  assign ctrl_seen = ctrl;

  always_comb begin
    if (ctrl_seen[ER_B])      nxt = base & AMASK;
    else if (ctrl_seen[CH_B]) nxt = link & AMASK;
    else                      nxt = cur + STRIDE;
  end
endmodule

// File: rtl/tdw_idle_ctr.sv
module tdw_idle_ctr #(
  parameter int IDLE_LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic preload,
  input  logic step,
  output logic tu
);
  localparam int CW = $clog2(IDLE_LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tu  <= 1'b0;
    end else begin
      tu <= 1'b0;
      if (preload) begin
        cnt <= LIM;
      end else if (step) begin
        if (cnt > LIM) begin
          cnt <= '0;
          tu  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TU_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    tu |-> ($past(step) && !$past(preload))); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM + 1'b1); // R4
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tdw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDLE_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              poll,
  input  logic [ADDR_W-1:0] list_base,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [ADDR_W-1:0] next_desc,
  output logic              evt_complete,
  output logic              evt_no_buf,
  output logic              evt_halted
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] AMASK = {1'b0, {(ADDR_W-3){1'b1}}, 2'b00};

  walk_st_t          st;
  wb_kind_t          wb_kind;
  logic              en_q;
  logic [ADDR_W-1:0] cur_ptr, dbase, baddr, nxt_ptr;
  logic [WORD_W-1:0] desc_w [4];
  logic [1:0]        idx, wb_idx, wb_top;
  logic [SIZE_W-1:0] bsize, bcnt, size1, size2;
  logic [WORD_W-1:0] wbuf;
  logic              first_pend;
  logic              en_rise, idle_step, byte_end;

  assign en_rise   = enable & ~en_q;
  assign idle_step = (st == ST_CAPT) && (idx == 2'd0) && !mem_rdata[OWN_B];
  assign size1     = desc_w[1][SIZE_W-1:0];
  assign size2     = desc_w[1][2*SIZE_W-1:SIZE_W];
  assign byte_end  = (bcnt == bsize - 1'b1);
  assign wb_top    = (wb_kind == WB_FINAL) ? 2'd0 : 2'd3;

  tdw_next_ptr #(.ADDR_W(ADDR_W)) u_next (
    .cur  (cur_ptr),
    .base (list_base),
    .ctrl (desc_w[1]),
    .link (desc_w[3][ADDR_W-1:0]),
    .nxt  (nxt_ptr)
  );

  tdw_idle_ctr #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .preload (poll),
    .step    (idle_step),
    .tu      (evt_no_buf)
  );

  always_ff @(posedge clk) en_q <= enable;

  always_ff @(posedge clk) begin
    if (rst) evt_halted <= 1'b0;
    else     evt_halted <= en_q & ~enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      wb_kind      <= WB_PART;
      cur_ptr      <= '0;
      dbase        <= '0;
      baddr        <= '0;
      idx          <= '0;
      wb_idx       <= '0;
      bsize        <= '0;
      bcnt         <= '0;
      wbuf         <= '0;
      first_pend   <= 1'b0;
      evt_complete <= 1'b0;
      for (int i = 0; i < 4; i++) desc_w[i] <= '0;
    end else begin
      evt_complete <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (enable && (poll || en_rise)) begin
            if (en_rise) cur_ptr <= list_base & AMASK;
            idx <= 2'd0;
            st  <= ST_FETCH;
          end
        end
        ST_FETCH: st <= enable ? ST_CAPT : ST_IDLE;
        ST_CAPT: begin
          desc_w[idx] <= mem_rdata;
          if (idx == 2'd0 && !mem_rdata[OWN_B]) st <= ST_IDLE;
          else if (idx == 2'd3)                 st <= ST_PLAN;
          else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        ST_PLAN: begin
          dbase   <= cur_ptr;
          cur_ptr <= nxt_ptr;
          bcnt    <= '0;
          wb_idx  <= '0;
          if (size1 != '0) begin
            bsize <= size1;
            baddr <= desc_w[2][ADDR_W-1:0] & AMASK;
          end else begin
            bsize <= size2;
            baddr <= desc_w[3][ADDR_W-1:0] & AMASK;
          end
          if (desc_w[1][SET_B]) begin
            wb_kind <= WB_SETUP;
            st      <= ST_WBACK;
          end else begin
            first_pend <= desc_w[1][FS_B];
            wb_kind    <= desc_w[1][LS_B] ? WB_FINAL : WB_PART;
            st <= (((size1 != '0) ? size1 : size2) == '0) ? ST_WBACK : ST_BREAD;
          end
        end
        ST_BREAD: st <= ST_BLOAD;
        ST_BLOAD: begin
          wbuf <= mem_rdata;
          st   <= ST_BOUT;
        end
        ST_BOUT: begin
          if (out_ready) begin
            wbuf       <= wbuf >> 8;
            first_pend <= 1'b0;
            bcnt       <= bcnt + 1'b1;
            if (byte_end)               st <= ST_WBACK;
            else if (bcnt[1:0] == 2'd3) st <= ST_BREAD;
          end
        end
        ST_WBACK: begin
          if (wb_idx == wb_top) begin
            evt_complete <= desc_w[1][IC_B] && (wb_kind != WB_PART);
            idx <= 2'd0;
            st  <= enable ? ST_FETCH : ST_IDLE;
          end else begin
            wb_idx <= wb_idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_FETCH: begin
        mem_rd   = enable;
        mem_addr = cur_ptr[ADDR_W-1:2] + WIDX_W'(idx);
      end
      ST_BREAD: begin
        mem_rd   = 1'b1;
        mem_addr = baddr[ADDR_W-1:2] + WIDX_W'(bcnt[SIZE_W-1:2]);
      end
      ST_WBACK: begin
        mem_wr   = 1'b1;
        mem_addr = dbase[ADDR_W-1:2] + WIDX_W'(wb_idx);
        case (wb_kind)
          WB_SETUP: mem_wdata = (wb_idx == 2'd0) ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
          WB_FINAL: mem_wdata = desc_w[0] & ~ERR_CLR & ~(32'h1 << OWN_B);
          default:  mem_wdata = (wb_idx == 2'd0) ? (desc_w[0] & ~ERR_CLR) : desc_w[wb_idx];
        endcase
      end
      default: ;
    endcase
  end

  assign out_valid = (st == ST_BOUT);
  assign out_data  = wbuf[7:0];
  assign out_first = out_valid & first_pend;
  assign out_last  = out_valid & (wb_kind == WB_FINAL) & byte_end;
  assign next_desc = cur_ptr;

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last))); // R7
  AST_MEM_QUIET_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!mem_rd && !mem_wr)); // R7
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_first) |=> !out_first); // R8
  AST_WB_IN_DESC: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ((mem_addr - dbase[ADDR_W-1:2]) < WIDX_W'(4))); // R9
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(enable) |=> evt_halted); // R12
  AST_NO_FETCH_OFF: assert property (@(posedge clk) disable iff (rst)
    (!enable && st != ST_BREAD) |-> !mem_rd); // R12
endmodule

// File: tb/tx_desc_walker_test.sv
module tx_desc_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic poll = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic mem_rd, mem_wr;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic out_valid, out_first, out_last;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [AW-1:0] next_desc;
  logic evt_complete, evt_no_buf, evt_halted;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_desc_walker #(.ADDR_W(AW), .IDLE_LIMIT(3)) uut (
    .clk(clk), .rst(rst), .enable(enable), .poll(poll), .list_base(list_base),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .next_desc(next_desc), .evt_complete(evt_complete), .evt_no_buf(evt_no_buf),
    .evt_halted(evt_halted)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  logic clr = 1'b0;
  logic stall = 1'b0;
  int rcnt = 0;
  logic [7:0] got_b [0:63];
  logic got_f [0:63];
  logic got_l [0:63];
  int got_n, n_done, n_nobuf, n_halt, n_rd, n_wr;

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    out_ready <= !stall || (rcnt % 3 != 0);
  end

  always @(posedge clk) begin
    if (clr) begin
      got_n <= 0; n_done <= 0; n_nobuf <= 0; n_halt <= 0; n_rd <= 0; n_wr <= 0;
    end else begin
      if (out_valid && out_ready && got_n < 64) begin
        got_b[got_n] <= out_data;
        got_f[got_n] <= out_first;
        got_l[got_n] <= out_last;
        got_n <= got_n + 1;
      end
      n_done  <= n_done + int'(evt_complete);
      n_nobuf <= n_nobuf + int'(evt_no_buf);
      n_halt  <= n_halt + int'(evt_halted);
      n_rd    <= n_rd + int'(mem_rd);
      n_wr    <= n_wr + int'(mem_wr);
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_counts();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic do_poll();
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
  endtask

  task automatic do_reset();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    @(negedge clk) rst = 1'b1; enable = 1'b0;
    cycles(3);
    @(negedge clk) rst = 1'b0;
    clear_counts();
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1 mem_rd/mem_wr", {30'b0, mem_rd, mem_wr}, 32'h0);
    chk("R1 next_desc", next_desc, 32'h0);
    chk("R1 events", {29'b0, evt_complete, evt_no_buf, evt_halted}, 32'h0);
  endtask

  task automatic t_single_frame();
    int nf = 0;
    int nl = 0;
    clear_counts();
    stall = 1'b1;
    mem[16] = 32'h8000_4010;
    mem[17] = 32'hE000_0006;           // IC|LS|FS, size1 = 6
    mem[18] = 32'h8000_0202;           // cleaned to 0x200
    mem[19] = 32'h0;
    mem[128] = 32'h4433_2211;
    mem[129] = 32'h0000_6655;
    mem[20] = 32'h0;                   // 0x50 not owned
    list_base = 32'h0000_0040;
    @(negedge clk) enable = 1'b1;
    cycles(200);
    chk("R7 byte count", got_n, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R7 R6 byte value", {24'b0, got_b[i]}, 32'(8'h11 * (i + 1)));
      nf += int'(got_f[i]);
      nl += int'(got_l[i]);
    end
    chk("R8 first on byte 0", {31'b0, got_f[0]}, 32'h1);
    chk("R8 one first", nf, 1);
    chk("R8 last on byte 5", {31'b0, got_l[5]}, 32'h1);
    chk("R8 one last", nl, 1);
    chk("R9 final word0", mem[16], 32'h0000_0010);
    chk("R9 final word1 untouched", mem[17], 32'hE000_0006);
    chk("R11 completion", n_done, 1);
    chk("R5 sequential next", next_desc, 32'h50);
    chk("R3 unowned not written", mem[20], 32'h0);
    chk("R3 writes only word0", n_wr, 1);
  endtask

  task automatic t_chain_ring();
    int nf = 0;
    int nl = 0;
    logic [7:0] exp_b [0:7];
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33;
    exp_b[3] = 8'hA1; exp_b[4] = 8'hA2; exp_b[5] = 8'hA3; exp_b[6] = 8'hA4; exp_b[7] = 8'hA5;
    clear_counts();
    mem[20] = 32'h8000_CF03;
    mem[21] = 32'h2100_0003;           // FS|CH, size1 = 3
    mem[22] = 32'h0000_0200;
    mem[23] = 32'h0000_0080;           // chain link
    mem[32] = 32'h8000_0004;
    mem[33] = 32'h4200_2800;           // LS|ER, size1 = 0, size2 = 5
    mem[34] = 32'h0000_0BAD;
    mem[35] = 32'h0000_0210;           // buffer 2
    mem[132] = 32'hA4A3_A2A1;
    mem[133] = 32'h0000_00A5;
    mem[40] = 32'h0;
    list_base = 32'h0000_00A0;
    do_poll();
    cycles(250);
    chk("R6 R7 byte count", got_n, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R6 R7 byte value", {24'b0, got_b[i]}, {24'b0, exp_b[i]});
      nf += int'(got_f[i]);
      nl += int'(got_l[i]);
    end
    chk("R8 first only byte 0", {31'b0, got_f[0]}, 32'h1);
    chk("R8 first count", nf, 1);
    chk("R8 last only byte 7", {31'b0, got_l[7]}, 32'h1);
    chk("R8 last count", nl, 1);
    chk("R9 partial word0", mem[20], 32'h8000_0001);
    chk("R9 partial word1", mem[21], 32'h2100_0003);
    chk("R9 partial word3", mem[23], 32'h0000_0080);
    chk("R9 final word0", mem[32], 32'h0000_0004);
    chk("R11 no completion without IC", n_done, 0);
    chk("R5 ring reload", next_desc, 32'hA0);
  endtask

  task automatic t_setup();
    clear_counts();
    mem[40] = 32'h8000_0000;
    mem[41] = 32'h8800_00C0;           // IC|SET, size1 = 192
    mem[42] = 32'h0000_0300;
    mem[43] = 32'h0;
    mem[44] = 32'h0;
    do_poll();
    cycles(80);
    chk("R10 no bytes", got_n, 0);
    chk("R10 word0", mem[40], 32'h7FFF_FFFF);
    chk("R10 word1", mem[41], 32'hFFFF_FFFF);
    chk("R10 word2", mem[42], 32'hFFFF_FFFF);
    chk("R10 word3", mem[43], 32'hFFFF_FFFF);
    chk("R11 setup completion", n_done, 1);
    chk("R5 after setup", next_desc, 32'hB0);
  endtask

  task automatic t_disable();
    clear_counts();
    mem[44] = 32'h8000_0000;
    mem[45] = 32'h4000_0000;
    @(negedge clk) enable = 1'b0;
    cycles(5);
    chk("R12 halt pulse", n_halt, 1);
    do_poll();
    cycles(30);
    chk("R12 no reads when off", n_rd, 0);
    chk("R12 descriptor untouched", mem[44], 32'h8000_0000);
    chk("R12 pointer held", next_desc, 32'hB0);
  endtask

  task automatic restart();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    cycles(10);
  endtask

  task automatic t_idle_count();
    do_reset();
    stall = 1'b0;
    list_base = 32'h8000_0043;
    @(negedge clk) enable = 1'b1;
    cycles(10);
    chk("R2 cleaned base", next_desc, 32'h40);
    for (int i = 0; i < 3; i++) restart();
    chk("R4 no event after four", n_nobuf, 0);
    restart();
    chk("R4 event on fifth", n_nobuf, 1);
    do_poll();
    cycles(10);
    chk("R4 preload then step", n_nobuf, 1);
    restart();
    chk("R4 event after preload", n_nobuf, 2);
    chk("R3 no bytes", got_n, 0);
    chk("R3 no writes", n_wr, 0);
    chk("R3 pointer stays", next_desc, 32'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_single_frame();
    t_chain_ring();
    t_setup();
    t_disable();
    t_idle_count();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule